// File: doc/BRIEF.md
# Multi-Drive Attention Interrupt Combiner

This block merges two kinds of interrupt source in a disk controller onto one request line. The first is a completion request. A flip-flop captures the interrupt-enable value at the moment the controller's ready flag rises, which means the data transfer has finished. The second is a level request from a bank of per-drive attention flags. A drive raises its flag with a one-cycle pulse, and the flag stays up until software clears it through a write-one-to-clear register port. The same port also returns the current attention summary.

Initialization clears the completion flip-flop and every attention flag. Interrupt acknowledge clears only the completion flip-flop. Any attention flag that is still set therefore keeps the request asserted after an acknowledge. A mode input selects between two ways of combining the sources:

- **Legacy mode** reproduces an old combination. Once the completion request is latched, it reaches the output even after enable or ready drops.
- **Masked mode** gates the whole request with both enable and ready, so that software can always suppress it.

Top module: `attn_irq_combiner`

## Requirements
- R1: After reset, the attention summary reads all zeros and the request output is 0.
- R2: A 1 on bit i of the attention-set input sets drive i's flag. From the next cycle it reads as 1 on bit i of the summary output. Several drives can be set in the same cycle.
- R3: A register write clears flag i when bit i of the write data is 1. Flags whose write-data bit is 0 keep their value.
- R4: If a drive's set pulse arrives in the same cycle as a write that clears that drive's flag, the flag ends up set.
- R5: In both modes the attention term drives the request high only while at least one flag is set, enable is 1 and ready is 1. With every flag clear and no completion latched, the request is 0.
- R6: On a 0-to-1 transition of ready, the completion flip-flop loads the value enable has in that cycle. A rising edge seen with enable at 0 latches nothing, and raising enable afterwards does not raise the request.
- R7: Interrupt acknowledge clears the completion flip-flop and leaves the attention flags unchanged. A flag that stays set keeps the request asserted.
- R8: Initialization clears every attention flag and the completion flip-flop on the next clock edge.
- R9: When the mode input is 0 (legacy), a latched completion request holds the output at 1 even when enable or ready is 0.
- R10: When the mode input is 1 (masked), the output is 0 whenever enable or ready is 0. A completion request that is still latched reappears once both are 1 again.
- R11: Initialization takes priority over a set pulse that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Controller initialize, clears all request state |
| iack_i | input | 1 | Interrupt acknowledge, clears the completion request |
| ready_i | input | 1 | Controller ready, 1 when no transfer is in progress |
| irq_en_i | input | 1 | Interrupt enable |
| mode_masked_i | input | 1 | 0 selects legacy combining, 1 selects masked combining |
| drv_attn_set_i | input | NUM_DRIVES | Per-drive attention-set pulses |
| reg_wr_i | input | 1 | Attention register write strobe |
| reg_wdata_i | input | NUM_DRIVES | Write-one-to-clear mask for the attention flags |
| attn_summary_o | output | NUM_DRIVES | Current attention flags, bit i for drive i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default of eight drives. Setting drives 0 and 7 together therefore exercises both ends of the summary, and a simultaneous set and clear on one bit exercises the priority rule. Both mode values run through the same completion sequence with enable and ready toggled separately. This makes the difference between the legacy escape and the masked behaviour visible at the request pin. Acknowledge is also applied while an attention flag is pending, so the bench can confirm that the level request survives the clearing of the completion request.

// File: rtl/attn_irq_pkg.sv
// Shared types for the attention interrupt combiner.
package attn_irq_pkg;
    // Selects how the completion and attention terms are merged.
    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_MASKED = 1'b1
    } irq_mode_e;
endpackage

// File: rtl/attn_flag_bank.sv
// One sticky attention flag per drive.
// Set by a one-cycle pulse, cleared by a write-one-to-clear mask.
// Assumes: a set pulse beats a clear in the same cycle; init beats both.
module attn_flag_bank #(
    parameter int NUM_DRIVES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_i,
    input  logic [NUM_DRIVES-1:0] set_i,
    input  logic                  clr_wr_i,
    input  logic [NUM_DRIVES-1:0] clr_mask_i,
    output logic [NUM_DRIVES-1:0] flags_o
);
    logic [NUM_DRIVES-1:0] flag_q;

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_flag
        logic clr_hit;
        assign clr_hit = clr_wr_i & clr_mask_i[d];

        // Per-drive flag update: reset/init clear, set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n || init_i) begin
                flag_q[d] <= 1'b0;
            end else if (set_i[d]) begin
                flag_q[d] <= 1'b1;
            end else if (clr_hit) begin
                flag_q[d] <= 1'b0;
            end
        end
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/done_edge_latch.sv
// Completion request latch.
// On a rising edge of ready it captures the enable value. Init or
// acknowledge clears it.
// Assumes: the ready history starts at 1, so that a ready already high
// at reset release is not taken as an edge. A clear beats a load in the
// same cycle.
module done_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic iack_i,
    input  logic ready_i,
    input  logic en_i,
    output logic done_o
);
    logic ready_prev_q;
    logic done_q;
    logic ready_rise;

    assign ready_rise = ready_i & ~ready_prev_q;

    // Track the previous ready value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_prev_q <= 1'b1;
        end else begin
            ready_prev_q <= ready_i;
        end
    end

    // Completion flip-flop: clear on init/ack, load enable on a ready rise.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i || iack_i) begin
            done_q <= 1'b0;
        end else if (ready_rise) begin
            done_q <= en_i;
        end
    end

    assign done_o = done_q;
endmodule

// File: rtl/irq_merge.sv
// Combines the completion request with the attention summary.
// Legacy: the completion term bypasses the enable/ready gating.
// Masked: both terms are gated by enable and ready.
// Assumes: purely combinational, feeding the request pin directly.
module irq_merge
    import attn_irq_pkg::*;
#(
    parameter int NUM_DRIVES = 8
) (
    input  irq_mode_e             mode_i,
    input  logic [NUM_DRIVES-1:0] flags_i,
    input  logic                  done_i,
    input  logic                  en_i,
    input  logic                  ready_i,
    output logic                  irq_o
);
    logic any_attn;
    logic gate_ok;

    assign any_attn = |flags_i;
    assign gate_ok  = en_i & ready_i;

    // Select the combining rule for the current mode.
    always_comb begin
        unique case (mode_i)
            MODE_LEGACY: irq_o = done_i | (any_attn & gate_ok);
            MODE_MASKED: irq_o = (done_i | any_attn) & gate_ok;
            default:     irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/attn_irq_combiner.sv
// Top level: attention flag bank, completion latch and request merge.
// Assumes: all inputs are synchronous to clk. Set pulses are single-cycle.
module attn_irq_combiner
    import attn_irq_pkg::*;
#(
    parameter int NUM_DRIVES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_i,
    input  logic                  iack_i,
    input  logic                  ready_i,
    input  logic                  irq_en_i,
    input  logic                  mode_masked_i,
    input  logic [NUM_DRIVES-1:0] drv_attn_set_i,
    input  logic                  reg_wr_i,
    input  logic [NUM_DRIVES-1:0] reg_wdata_i,
    output logic [NUM_DRIVES-1:0] attn_summary_o,
    output logic                  irq_o
);
    logic [NUM_DRIVES-1:0] flags;
    logic                  done;
    irq_mode_e             mode;

    assign mode = irq_mode_e'(mode_masked_i);

    attn_flag_bank #(.NUM_DRIVES(NUM_DRIVES)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .set_i      (drv_attn_set_i),
        .clr_wr_i   (reg_wr_i),
        .clr_mask_i (reg_wdata_i),
        .flags_o    (flags)
    );

    done_edge_latch u_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init_i),
        .iack_i  (iack_i),
        .ready_i (ready_i),
        .en_i    (irq_en_i),
        .done_o  (done)
    );

    irq_merge #(.NUM_DRIVES(NUM_DRIVES)) u_merge (
        .mode_i  (mode),
        .flags_i (flags),
        .done_i  (done),
        .en_i    (irq_en_i),
        .ready_i (ready_i),
        .irq_o   (irq_o)
    );

    assign attn_summary_o = flags;
endmodule

// File: rtl/attn_irq_checker.sv
// Property checker for the attention interrupt combiner, bound to the top.
// Assumes: it observes top-level ports only.
module attn_irq_checker #(
    parameter int NUM_DRIVES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  init_i,
    input logic                  iack_i,
    input logic                  ready_i,
    input logic                  irq_en_i,
    input logic                  mode_masked_i,
    input logic [NUM_DRIVES-1:0] drv_attn_set_i,
    input logic                  reg_wr_i,
    input logic [NUM_DRIVES-1:0] reg_wdata_i,
    input logic [NUM_DRIVES-1:0] attn_summary_o,
    input logic                  irq_o
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (attn_summary_o == '0));

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && (drv_attn_set_i != '0))
        |=> ((attn_summary_o & $past(drv_attn_set_i)) == $past(drv_attn_set_i)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> ((attn_summary_o & $past(reg_wdata_i & ~drv_attn_set_i)) == '0));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && reg_wr_i && ((reg_wdata_i & drv_attn_set_i) != '0))
        |=> ((attn_summary_o & $past(reg_wdata_i & drv_attn_set_i)) != '0));

    assert_level_attn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && ready_i && (attn_summary_o != '0)) |-> irq_o);

    assert_ack_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && !init_i && !reg_wr_i && (drv_attn_set_i == '0))
        |=> $stable(attn_summary_o));

    assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (attn_summary_o == '0));

    assert_masked_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_masked_i && !(irq_en_i && ready_i)) |-> !irq_o);
endmodule

bind attn_irq_combiner attn_irq_checker #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .init_i         (init_i),
    .iack_i         (iack_i),
    .ready_i        (ready_i),
    .irq_en_i       (irq_en_i),
    .mode_masked_i  (mode_masked_i),
    .drv_attn_set_i (drv_attn_set_i),
    .reg_wr_i       (reg_wr_i),
    .reg_wdata_i    (reg_wdata_i),
    .attn_summary_o (attn_summary_o),
    .irq_o          (irq_o)
);

// File: tb/attn_irq_combiner_tb.sv
module attn_irq_combiner_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0;
    logic         iack_i = 1'b0;
    logic         ready_i = 1'b1;
    logic         irq_en_i = 1'b0;
    logic         mode_masked_i = 1'b0;
    logic [N-1:0] drv_attn_set_i = '0;
    logic         reg_wr_i = 1'b0;
    logic [N-1:0] reg_wdata_i = '0;
    logic [N-1:0] attn_summary_o;
    logic         irq_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    attn_irq_combiner #(.NUM_DRIVES(N)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .init_i         (init_i),
        .iack_i         (iack_i),
        .ready_i        (ready_i),
        .irq_en_i       (irq_en_i),
        .mode_masked_i  (mode_masked_i),
        .drv_attn_set_i (drv_attn_set_i),
        .reg_wr_i       (reg_wr_i),
        .reg_wdata_i    (reg_wdata_i),
        .attn_summary_o (attn_summary_o),
        .irq_o          (irq_o)
    );

    // One clock edge, then back to the falling edge for driving and sampling.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_sum(input string tag, input logic [N-1:0] exp);
        chk(attn_summary_o == exp, tag, int'(attn_summary_o), int'(exp));
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        chk(irq_o == exp, tag, int'(irq_o), int'(exp));
    endtask

    task automatic pulse_set(input logic [N-1:0] m);
        drv_attn_set_i = m;
        tick();
        drv_attn_set_i = '0;
    endtask

    task automatic w1c(input logic [N-1:0] m);
        reg_wr_i = 1'b1;
        reg_wdata_i = m;
        tick();
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic do_init();
        init_i = 1'b1;
        tick();
        init_i = 1'b0;
    endtask

    task automatic do_ack();
        iack_i = 1'b1;
        tick();
        iack_i = 1'b0;
    endtask

    // Lower ready for one cycle, then raise it with the given enable value.
    task automatic ready_edge(input logic en);
        ready_i = 1'b0;
        tick();
        irq_en_i = en;
        ready_i = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk_sum("R1 summary after reset", '0);
        chk_irq("R1 irq after reset", 1'b0);
    endtask

    task automatic t_attention_set();
        mode_masked_i = 1'b0;
        irq_en_i = 1'b1;
        ready_i = 1'b1;
        tick();
        chk_irq("R5 idle irq low", 1'b0);
        pulse_set(8'h08);
        chk_sum("R2 drive3 set", 8'h08);
        chk_irq("R5 attention raises irq", 1'b1);
        pulse_set(8'h81);
        chk_sum("R2 drives 0 and 7 set", 8'h89);
        irq_en_i = 1'b0;
        #1;
        chk_irq("R5 enable low masks attention", 1'b0);
        irq_en_i = 1'b1;
        ready_i = 1'b0;
        #1;
        chk_irq("R5 ready low masks attention", 1'b0);
        ready_i = 1'b1;
        tick();
    endtask

    task automatic t_w1c();
        w1c(8'h00);
        chk_sum("R3 zero mask keeps flags", 8'h89);
        w1c(8'h08);
        chk_sum("R3 clear drive3 only", 8'h81);
    endtask

    task automatic t_priority();
        reg_wr_i = 1'b1;
        reg_wdata_i = 8'h81;
        drv_attn_set_i = 8'h01;
        tick();
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
        drv_attn_set_i = '0;
        chk_sum("R4 set beats clear", 8'h01);
    endtask

    task automatic t_init();
        init_i = 1'b1;
        drv_attn_set_i = 8'h40;
        tick();
        init_i = 1'b0;
        drv_attn_set_i = '0;
        chk_sum("R8 R11 init clears and beats set", 8'h00);
        chk_irq("R8 irq low after init", 1'b0);
    endtask

    task automatic t_legacy_completion();
        mode_masked_i = 1'b0;
        ready_edge(1'b1);
        chk_irq("R6 ready rise with enable latches", 1'b1);
        irq_en_i = 1'b0;
        tick();
        chk_irq("R9 legacy ignores enable low", 1'b1);
        ready_i = 1'b0;
        tick();
        chk_irq("R9 legacy ignores ready low", 1'b1);
        ready_i = 1'b1;
        tick();
        do_ack();
        chk_irq("R7 ack clears completion", 1'b0);
        irq_en_i = 1'b1;
        tick();
        chk_irq("R7 stays clear after ack", 1'b0);
    endtask

    task automatic t_rise_disabled();
        mode_masked_i = 1'b0;
        ready_edge(1'b0);
        chk_irq("R6 rise with enable low no request", 1'b0);
        irq_en_i = 1'b1;
        tick();
        chk_irq("R6 later enable does not raise", 1'b0);
    endtask

    task automatic t_masked_completion();
        mode_masked_i = 1'b1;
        ready_edge(1'b1);
        chk_irq("R10 masked completion visible", 1'b1);
        irq_en_i = 1'b0;
        tick();
        chk_irq("R10 masked enable low blocks", 1'b0);
        irq_en_i = 1'b1;
        tick();
        chk_irq("R10 request returns with enable", 1'b1);
        ready_i = 1'b0;
        tick();
        chk_irq("R10 masked ready low blocks", 1'b0);
        ready_i = 1'b1;
        tick();
        do_ack();
        chk_irq("R7 ack clears masked completion", 1'b0);
    endtask

    task automatic t_ack_with_attention();
        mode_masked_i = 1'b0;
        pulse_set(8'h20);
        ready_edge(1'b1);
        do_ack();
        chk_sum("R7 ack leaves flags", 8'h20);
        chk_irq("R7 attention keeps irq after ack", 1'b1);
        w1c(8'h20);
        chk_irq("R3 irq drops after last flag cleared", 1'b0);
        pulse_set(8'h02);
        ready_edge(1'b1);
        do_init();
        chk_sum("R8 init clears flags", 8'h00);
        chk_irq("R8 init clears completion", 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_attention_set();
        t_w1c();
        t_priority();
        t_init();
        t_legacy_completion();
        t_rise_disabled();
        t_masked_completion();
        t_ack_with_attention();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule